// File: doc/BRIEF.md
# Dual-Style Host Bus Register Interface

This block is the slave side of a 16-bit microprocessor bus in front of a banked register file. Two static pins choose the bus signalling and the address source. The first picks one of two strobe styles: separate active-low read and write strobes, or a direction signal with one active-low data strobe. The second picks where the address comes from: dedicated word-address pins, or the low data lines, captured while the address-latch-enable input is high.

All strobe, select and bus inputs pass through a two-stage synchronizer into the system clock. The block decodes a 5-bit word address into a flat register index. The lower eight words and the bank-select word look the same in every bank. The 23 words between them are routed to the bank that is currently selected. Reads return the word that the register file supplies for the live index. A write produces one single-cycle one-hot write enable after the strobe ends. An interrupt line is set by the register file and cleared when the host finishes reading the interrupt code word.

Read and write indices are separate outputs. The register file can therefore place different registers behind the same offset for the two directions.

Top module: `hostbus_regif`

## Requirements
- R1: While reset is high and on the first cycle after it, data_oe, every wr_en bit and irq are 0, and the selected bank is 0.
- R2: With bus_style_dir=0, chip select and rd_n_or_rw both low make an access a read. data_oe rises, and data_out carries the word for the addressed register, on the third rising edge after the inputs change.
- R3: With bus_style_dir=1, a read is chip select low with wr_n_or_ds_n low and rd_n_or_rw high. A write is the same but with rd_n_or_rw low.
- R4: With addr_muxed=0 the word address is taken from addr_in. With addr_muxed=1 it is taken from data_in[5:1] while ale is high, and that value is held after ale falls.
- R5: Each write access produces exactly one wr_en pulse, one cycle long and one-hot. It appears on the third rising edge after the strobe is released, and wr_data carries the data that was present during the strobe.
- R6: Word addresses 0 to 7 map to index = word in every bank. Words 8 to 30 map to index 8 + 23*bank + (word-8). Word 31 is the bank-select register and raises no wr_en bit.
- R7: Writing 0, 1 or 2 to word 31 selects that bank. Any other value leaves the bank unchanged. Reading word 31 returns the bank number in bits [1:0], with zeros above.
- R8: A read access never raises a wr_en bit.
- R9: irq_set high sets irq at the next edge. irq then stays high until a read of word 1 ends, and it falls at the same edge where that read leaves data_oe. irq_set wins when both happen together.
- R10: Strobes while chip select is high cause neither a read nor a write.
- R11: Outside a read access data_oe is 0 and data_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_style_dir | input | 1 | 0: separate read/write strobes; 1: direction plus data strobe |
| addr_muxed | input | 1 | 0: address on addr_in; 1: address on data_in[5:1] under ale |
| cs_n | input | 1 | Active-low chip select |
| rd_n_or_rw | input | 1 | Read strobe (style 0) or direction, 1 = read (style 1) |
| wr_n_or_ds_n | input | 1 | Write strobe (style 0) or data strobe (style 1), active low |
| ale | input | 1 | Address latch enable, tied 0 when not multiplexed |
| addr_in | input | 5 | Word address, tied 0 when multiplexed |
| data_in | input | 16 | Host data and multiplexed address |
| data_out | output | 16 | Read data towards the host |
| data_oe | output | 1 | High while the block drives the data bus |
| wr_en | output | 77 | One-hot register write enables |
| wr_data | output | 16 | Data for the enabled register |
| rd_idx | output | 7 | Register index of the current read address |
| rd_word | input | 16 | Register file word for rd_idx |
| irq_set | input | 1 | Interrupt event from the register file |
| irq | output | 1 | Interrupt towards the host |

## Verification
All four combinations of strobe style and address source are exercised. Each combination performs writes and reads to common words, banked words and the bank-select word, so that a fault in one style's direction decode or in the ALE capture shows up only in that combination. Reads and writes are repeated after each bank switch, including a switch with an out-of-range value, which tells a wrong bank stride apart from an ignored bank write. Strobes without chip select and a read of a non-interrupt word between the interrupt event and the code read separate the interrupt-clear condition from any other read.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
  // decoded access kind after synchronization
  typedef struct packed {
    logic rd;
    logic wr;
  } acc_t;
endpackage

// File: rtl/hbr_sync.sv
module hbr_sync #(
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage1;

  // all bits move in lock-step so address, data and strobes stay aligned
  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= RST_VAL;
      dout   <= RST_VAL;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/hbr_decode.sv
module hbr_decode #(
  parameter int ADDR_W       = 5,
  parameter int COMMON_WORDS = 8,
  parameter int BANKED_WORDS = 23,
  parameter int BANK_W       = 2,
  parameter int IDX_W        = 7
) (
  input  logic [ADDR_W-1:0] word,
  input  logic [BANK_W-1:0] bank,
  output logic [IDX_W-1:0]  idx,
  output logic              bank_reg
);
  int flat;

  always_comb begin
    if (int'(word) < COMMON_WORDS)
      flat = int'(word);
    else
      flat = COMMON_WORDS + int'(bank) * BANKED_WORDS + (int'(word) - COMMON_WORDS);
    idx      = flat[IDX_W-1:0];
    bank_reg = (word == {ADDR_W{1'b1}});
  end
endmodule

// File: rtl/hbr_irq.sv
module hbr_irq (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst)      irq <= 1'b0;
    else if (set) irq <= 1'b1;
    else if (clr) irq <= 1'b0;
  end

  assert_irq_set_R9: assert property (@(posedge clk) disable iff (rst)
    set |=> irq);
  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !irq);
endmodule

// File: rtl/hostbus_regif.sv
module hostbus_regif #(
  parameter int DATA_W        = 16,
  parameter int ADDR_W        = 5,
  parameter int NUM_BANKS     = 3,
  parameter int COMMON_WORDS  = 8,
  parameter int IRQ_CODE_WORD = 1,
  parameter int BANKED_WORDS  = (1 << ADDR_W) - 1 - COMMON_WORDS,
  parameter int IDX_N         = COMMON_WORDS + NUM_BANKS * BANKED_WORDS,
  parameter int IDX_W         = $clog2(IDX_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_style_dir,
  input  logic              addr_muxed,
  input  logic              cs_n,
  input  logic              rd_n_or_rw,
  input  logic              wr_n_or_ds_n,
  input  logic              ale,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic [IDX_N-1:0]  wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [DATA_W-1:0] rd_word,
  input  logic              irq_set,
  output logic              irq
);
  import hbr_pkg::*;

  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int BUS_W  = DATA_W + ADDR_W;
  localparam logic [ADDR_W-1:0] IRQ_WORD = ADDR_W'(IRQ_CODE_WORD);

  // synchronized pins: {cs_n, rd_n_or_rw, wr_n_or_ds_n, ale}
  logic [3:0]        ctl_q;
  logic [BUS_W-1:0]  bus_q;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] addr_q;

  hbr_sync #(.WIDTH(4), .RST_VAL(4'b1110)) u_ctl_sync (
    .clk(clk), .rst(rst),
    .din({cs_n, rd_n_or_rw, wr_n_or_ds_n, ale}),
    .dout(ctl_q)
  );

  hbr_sync #(.WIDTH(BUS_W), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst(rst),
    .din({data_in, addr_in}),
    .dout(bus_q)
  );

  assign data_q = bus_q[BUS_W-1:ADDR_W];
  assign addr_q = bus_q[ADDR_W-1:0];

  // access decode for both strobe styles
  acc_t acc;
  always_comb begin
    if (bus_style_dir) begin
      acc.rd = !ctl_q[3] && !ctl_q[1] &&  ctl_q[2];
      acc.wr = !ctl_q[3] && !ctl_q[1] && !ctl_q[2];
    end else begin
      acc.rd = !ctl_q[3] && !ctl_q[2];
      acc.wr = !ctl_q[3] && !ctl_q[1] && ctl_q[2];
    end
  end

  logic [ADDR_W-1:0] mux_word, live_word, acc_word;
  logic [DATA_W-1:0] wr_hold;
  logic [BANK_W-1:0] bank_q;
  logic              rd_prev, wr_prev;
  logic              wr_done, rd_done;
  logic [IDX_W-1:0]  wr_idx;
  logic              live_is_bank, held_is_bank;

  assign live_word = addr_muxed ? mux_word : addr_q;
  assign wr_done   = wr_prev && !acc.wr;
  assign rd_done   = rd_prev && !acc.rd;

  hbr_decode #(
    .ADDR_W(ADDR_W), .COMMON_WORDS(COMMON_WORDS), .BANKED_WORDS(BANKED_WORDS),
    .BANK_W(BANK_W), .IDX_W(IDX_W)
  ) u_rd_dec (.word(live_word), .bank(bank_q), .idx(rd_idx), .bank_reg(live_is_bank));

  hbr_decode #(
    .ADDR_W(ADDR_W), .COMMON_WORDS(COMMON_WORDS), .BANKED_WORDS(BANKED_WORDS),
    .BANK_W(BANK_W), .IDX_W(IDX_W)
  ) u_wr_dec (.word(acc_word), .bank(bank_q), .idx(wr_idx), .bank_reg(held_is_bank));

  always_ff @(posedge clk) begin
    if (rst) begin
      mux_word <= '0;
      acc_word <= '0;
      wr_hold  <= '0;
      bank_q   <= '0;
      rd_prev  <= 1'b0;
      wr_prev  <= 1'b0;
      data_out <= '0;
      data_oe  <= 1'b0;
      wr_data  <= '0;
    end else begin
      rd_prev <= acc.rd;
      wr_prev <= acc.wr;
      if (ctl_q[0]) mux_word <= data_q[ADDR_W:1];
      if (acc.rd || acc.wr) acc_word <= live_word;
      if (acc.wr) wr_hold <= data_q;
      data_oe  <= acc.rd;
      data_out <= acc.rd ? (live_is_bank ? DATA_W'(bank_q) : rd_word) : '0;
      if (wr_done) wr_data <= wr_hold;
      if (wr_done && held_is_bank && (wr_hold < DATA_W'(NUM_BANKS)))
        bank_q <= wr_hold[BANK_W-1:0];
    end
  end

  // one enable flop per register index
  for (genvar gi = 0; gi < IDX_N; gi++) begin : g_we
    always_ff @(posedge clk) begin
      if (rst) wr_en[gi] <= 1'b0;
      else     wr_en[gi] <= wr_done && !held_is_bank && (wr_idx == IDX_W'(gi));
    end
  end

  hbr_irq u_irq (
    .clk(clk), .rst(rst),
    .set(irq_set),
    .clr(rd_done && (acc_word == IRQ_WORD)),
    .irq(irq)
  );

  assert_onehot_we_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en));
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en != '0) |=> (wr_en == '0));
  assert_bank_range_R7: assert property (@(posedge clk) disable iff (rst)
    int'(bank_q) < NUM_BANKS);
  assert_quiet_bus_R11: assert property (@(posedge clk) disable iff (rst)
    !data_oe |-> (data_out == '0));
endmodule

// File: tb/tb_hostbus_regif.sv
module tb_hostbus_regif;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        style = 1'b0, muxed = 1'b0;
  logic        cs_n = 1'b1, rdrw = 1'b1, wrds = 1'b1, ale = 1'b0;
  logic [4:0]  addr_in = '0;
  logic [15:0] data_in = '0;
  logic [15:0] data_out, wr_data, rd_word;
  logic        data_oe, irq, irq_set = 1'b0;
  logic [76:0] wr_en;
  logic [6:0]  rd_idx;

  int checks = 0, fails = 0, cycles = 0;

  always #5 clk = ~clk;

  hostbus_regif dut (
    .clk(clk), .rst(rst), .bus_style_dir(style), .addr_muxed(muxed),
    .cs_n(cs_n), .rd_n_or_rw(rdrw), .wr_n_or_ds_n(wrds), .ale(ale),
    .addr_in(addr_in), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .wr_en(wr_en), .wr_data(wr_data), .rd_idx(rd_idx), .rd_word(rd_word),
    .irq_set(irq_set), .irq(irq)
  );

  // register file stand-in: each index returns a recognisable word
  function automatic logic [15:0] pat(input int idx);
    logic [6:0] i7;
    i7 = 7'(idx);
    return {i7, 2'b10, ~i7};
  endfunction
  assign rd_word = pat(int'(rd_idx));

  // index map from R6
  function automatic int ref_idx(input int word, input int bank);
    if (word < 8) return word;
    return 8 + 23 * bank + (word - 8);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model, stepped on every rising edge ----------
  logic [3:0]  m_c1, m_c2;
  logic [20:0] m_b1, m_b2;
  int          m_mux, m_accw, m_bank;
  logic [15:0] m_wdata;
  bit          m_wrprev, m_rdprev, m_irq;
  logic [76:0] e_we;
  logic [15:0] e_wdata, e_dout;
  bit          e_oe;

  always @(posedge clk) begin
    if (rst) begin
      m_c1 = 4'b1110; m_c2 = 4'b1110; m_b1 = '0; m_b2 = '0;
      m_mux = 0; m_accw = 0; m_bank = 0; m_wdata = '0;
      m_wrprev = 0; m_rdprev = 0; m_irq = 0;
      e_we = '0; e_wdata = '0; e_dout = '0; e_oe = 0;
    end else begin
      bit sel, rd, wr, wdone;
      int w;
      sel = !m_c2[3];
      if (style) begin
        rd = sel && !m_c2[1] && m_c2[2];
        wr = sel && !m_c2[1] && !m_c2[2];
      end else begin
        rd = sel && !m_c2[2];
        wr = sel && !m_c2[1] && m_c2[2];
      end
      w = muxed ? m_mux : int'(m_b2[4:0]);
      e_oe   = rd;
      e_dout = !rd ? 16'h0 : (w == 31 ? 16'(m_bank) : pat(ref_idx(w, m_bank)));
      e_we   = '0;
      wdone  = m_wrprev && !wr;
      if (wdone) begin
        e_wdata = m_wdata;
        if (m_accw != 31) e_we[ref_idx(m_accw, m_bank)] = 1'b1;
        else if (m_wdata < 3) m_bank = int'(m_wdata);
      end
      if (irq_set) m_irq = 1;
      else if (m_rdprev && !rd && m_accw == 1) m_irq = 0;
      m_wrprev = wr; m_rdprev = rd;
      if (rd || wr) m_accw = w;
      if (wr) m_wdata = m_b2[20:5];
      if (m_c2[0]) m_mux = int'(m_b2[10:6]);
      m_c2 = m_c1; m_b2 = m_b1;
      m_c1 = {cs_n, rdrw, wrds, ale};
      m_b1 = {data_in, addr_in};
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      check(wr_en == e_we && (e_we == '0 || wr_data == e_wdata), "R5 R6 R8",
            "write enables/data", {3'b0, wr_en}, {3'b0, e_we});
      check(data_oe == e_oe && data_out == e_dout, "R2 R3 R4 R11",
            "read bus", {63'b0, data_oe, data_out}, {63'b0, e_oe, e_dout});
      check(irq == m_irq, "R9", "irq", {79'b0, irq}, {79'b0, m_irq});
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic access(input bit is_wr, input int word, input logic [15:0] wd,
                        output logic [15:0] rd_val);
    if (muxed) begin
      addr_in = '0; ale = 1'b1; data_in = 16'(word << 1);
      idle(2);
      ale = 1'b0;
      idle(1);
    end else addr_in = 5'(word);
    data_in = is_wr ? wd : 16'h0;
    cs_n = 1'b0;
    if (style) begin rdrw = !is_wr; wrds = 1'b0; end
    else if (is_wr) wrds = 1'b0;
    else rdrw = 1'b0;
    idle(4);
    rd_val = data_out;   // third edge after strobe has passed
    idle(1);
    cs_n = 1'b1; rdrw = 1'b1; wrds = 1'b1;
    idle(5);
  endtask

  task automatic wr(input int word, input logic [15:0] d);
    logic [15:0] dummy;
    access(1'b1, word, d, dummy);
  endtask

  task automatic rd(input int word, output logic [15:0] v);
    access(1'b0, word, 16'h0, v);
  endtask

  task automatic run_set();
    logic [15:0] v;
    wr(3, 16'h1234);
    wr(10, 16'hBEEF);
    rd(0, v);
    rd(12, v);
    wr(31, 16'h0002);            // R7 select bank 2
    rd(31, v);
    check(v == 16'h0002, "R7", "bank readback", {64'b0, v}, 80'h2);
    wr(30, 16'h5A5A);            // last banked word in bank 2
    rd(8, v);
    check(v == pat(54), "R6", "banked read", {64'b0, v}, {64'b0, pat(54)});
    wr(31, 16'h0005);            // R7 out of range: ignored
    rd(31, v);
    check(v == 16'h0002, "R7", "ignored bank write", {64'b0, v}, 80'h2);
    wr(31, 16'h0001);
    rd(3, v);
    check(v == pat(3), "R6", "common word in bank 1", {64'b0, v}, {64'b0, pat(3)});
    rd(20, v);
    check(v == pat(43), "R6", "banked word in bank 1", {64'b0, v}, {64'b0, pat(43)});
    wr(31, 16'h0000);
  endtask

  initial begin : main
    logic [15:0] v;
    idle(3);
    check(data_oe == 1'b0 && wr_en == '0 && irq == 1'b0, "R1", "reset outputs",
          {62'b0, data_oe, irq, data_out}, 80'h0);
    rst = 1'b0;
    @(negedge clk);
    check(data_oe == 1'b0 && wr_en == '0 && irq == 1'b0, "R1", "after reset",
          {62'b0, data_oe, irq, data_out}, 80'h0);
    idle(2);

    // R2: separate strobes, dedicated address pins
    style = 1'b0; muxed = 1'b0;
    run_set();
    rd(31, v);
    check(v == 16'h0000, "R1", "bank back to 0", {64'b0, v}, 80'h0);

    // R10: strobes with chip select inactive
    addr_in = 5'd4; data_in = 16'h7777;
    rdrw = 1'b0; idle(4);
    check(data_oe == 1'b0, "R10", "read without cs", {79'b0, data_oe}, 80'h0);
    rdrw = 1'b1; wrds = 1'b0; idle(4); wrds = 1'b1; idle(4);

    // R9: interrupt set, other read keeps it, code read clears it
    irq_set = 1'b1; @(negedge clk); irq_set = 1'b0;
    check(irq == 1'b1, "R9", "irq set", {79'b0, irq}, 80'h1);
    rd(5, v);
    check(irq == 1'b1, "R9", "irq held over other read", {79'b0, irq}, 80'h1);
    rd(1, v);
    check(irq == 1'b0, "R9", "irq cleared by code read", {79'b0, irq}, 80'h0);

    // R3: direction plus data strobe
    style = 1'b1; muxed = 1'b0; idle(2);
    run_set();

    // R4: multiplexed address, both strobe styles
    style = 1'b1; muxed = 1'b1; idle(2);
    run_set();
    style = 1'b0; muxed = 1'b1; idle(2);
    run_set();
    rd(2, v);
    check(v == pat(2), "R4", "multiplexed common read", {64'b0, v}, {64'b0, pat(2)});

    idle(5);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : watchdog
    wait (cycles > 100000);
    checks++; fails++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", cycles, 100000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule